// File: doc/BRIEF.md
# Quadrature Clock Divider with Sideband Sign Correction

This block divides one fast clock into two quadrature pairs. The high pair runs at half the input rate. Its in-phase signal comes from a toggle flop on the rising clock edge, and its quadrature signal from a toggle flop on the falling edge. A prescaler of toggle stages divides the in-phase signal further. A final toggle pair then takes the prescaled signal on its rising and falling transitions to form the low pair. With the default two prescale stages, the low pair runs at one eighth of the high pair's rate. The quadrature signal of each pair sits a quarter period from its reference. Whether it leads or lags depends on the toggle states at power-up, and those states are not known.

One sampling flop per pair captures the quadrature signal at each rising transition of that pair's reference. This gives a lead flag (1) or a lag flag (0). On every low-pair reference rise, the block loads an inversion control. The control is the sideband request XOR both sampled signs. The low quadrature signal is passed out through this inversion. The high pair is never altered. As a result, the requested mixer product is produced for every start-up combination.

Arbitrary power-up states are modelled by a start-state vector. The toggle flops load this vector while the synchronous active-high reset is held.

Top module: `quad_sideband_div`

## Requirements
- R1: While `rst` is high, the outputs take the start vector `start_st`. The mapping is: `hi_i`=bit 0, `hi_q`=bit 1, prescaler stage j=bit 2+j, `lo_i`=bit LO_STAGES+2, and `lo_q`=`lo_q_fix`=bit LO_STAGES+3. Also `hi_lead`=0, `lo_lead`=0 and `valid`=0.
- R2: Out of reset, `hi_i` inverts at every rising clock edge and `hi_q` inverts at every falling clock edge.
- R3: The toggle chain {`lo_i`, prescaler, `hi_i`} counts down by one at each rising clock edge. `lo_q` inverts at the rising clock edge where the last prescaler stage goes from 1 to 0. This places `lo_q` a quarter low period from `lo_i`.
- R4: At each rising edge where `hi_i` goes 0 to 1, `hi_lead` loads the value `hi_q` held just before that edge. At all other edges it holds.
- R5: At each rising edge where `lo_i` goes 0 to 1, `lo_lead` loads the value of `lo_q`. At all other edges it holds.
- R6: `lo_q_fix` equals `lo_q` XOR an inversion control. The control resets to 0. At each `lo_i` rise it loads `sel_lower` XOR the sampled `hi_q` XOR the sampled `lo_q`.
- R7: Just after each `lo_i` rise, the corrected sign `lo_q_fix` equals `hi_lead` XOR `sel_lower`. So `sel_lower`=0 (upper sideband) gives the low pair the same rotation as the high pair, and 1 gives the opposite rotation.
- R8: `valid` rises at the second `lo_i` rise after reset and stays high until reset.
- R9: A change of `sel_lower` between `lo_i` rises has no effect on `lo_q_fix` until the next `lo_i` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast input clock |
| rst | input | 1 | synchronous active-high reset, loads start states |
| start_st | input | LO_STAGES+4 | power-up states of all toggle flops |
| sel_lower | input | 1 | sideband request, 0 = upper, 1 = lower |
| hi_i | output | 1 | high pair, 0-degree signal |
| hi_q | output | 1 | high pair, quarter-shifted signal |
| lo_i | output | 1 | low pair, 0-degree signal |
| lo_q | output | 1 | low pair, raw quarter-shifted signal |
| lo_q_fix | output | 1 | low pair quarter signal after sign correction |
| hi_lead | output | 1 | 1 when `hi_q` leads `hi_i` |
| lo_lead | output | 1 | 1 when `lo_q` leads `lo_i` |
| valid | output | 1 | flags and correction settled |

## Verification
The bench steps through all 64 start-state vectors, so every lead/lag combination of both pairs appears with both sideband requests. A design that ignored one of the signs, or inverted the high pair instead, would give the wrong corrected rotation for half of those vectors.

The request is also flipped in the middle of a low period. A design that applied the new inversion at once would show a runt edge on `lo_q_fix` before the reference rise.

Flags sampled on the wrong edge, or taken after the quadrature signal had moved, would show up as flag values disagreeing with the bench's down-counter model. A `valid` that asserts one edge early or late would likewise be caught.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

  typedef struct packed {
    logic ref_sig;
    logic quad_sig;
    logic lead;
  } qsd_pair_t;

  // inversion control for the low quadrature signal
  function automatic logic qsd_fix_ctrl(input logic sel, input logic hi_samp, input logic lo_samp);
    return sel ^ hi_samp ^ lo_samp;
  endfunction

endpackage

// File: rtl/qsd_hi_pair.sv
module qsd_hi_pair (
  input  logic clk,
  input  logic rst,
  input  logic seed_i,
  input  logic seed_q,
  output logic ref_sig,
  output logic quad_sig,
  output logic lead,
  output logic ref_rise
);

  // the reference goes 0 -> 1 at this rising edge
  assign ref_rise = ~ref_sig;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sig <= seed_i;
      lead    <= 1'b0;
    end else begin
      ref_sig <= ~ref_sig;
      if (ref_rise) lead <= quad_sig;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) quad_sig <= seed_q;
    else     quad_sig <= ~quad_sig;
  end

  AST_HI_LEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    ref_sig |=> $stable(lead)); // R4

endmodule

// File: rtl/qsd_lo_pair.sv
module qsd_lo_pair #(
  parameter int LO_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hi_rise,
  input  logic [LO_STAGES-1:0] seed_pre,
  input  logic                 seed_i,
  input  logic                 seed_q,
  output logic                 ref_sig,
  output logic                 quad_sig,
  output logic                 lead,
  output logic                 ref_rise,
  output logic                 quad_step
);

  localparam int LAST = LO_STAGES - 1;

  logic [LO_STAGES-1:0] pre;
  logic [LO_STAGES:0]   adv;

  // advance strobe into each stage: a stage moves when its feeder rises
  always_comb begin
    logic carry;
    carry = hi_rise;
    for (int j = 0; j < LO_STAGES; j++) begin
      adv[j] = carry;
      carry  = carry & ~pre[j];
    end
    adv[LO_STAGES] = carry;
  end

  generate
    for (genvar g = 0; g < LO_STAGES; g++) begin : g_pre
      always_ff @(posedge clk) begin
        if (rst)         pre[g] <= seed_pre[g];
        else if (adv[g]) pre[g] <= ~pre[g];
      end
    end
  endgenerate

  assign ref_rise  = adv[LO_STAGES] & ~ref_sig;
  assign quad_step = adv[LAST] & pre[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sig  <= seed_i;
      quad_sig <= seed_q;
      lead     <= 1'b0;
    end else begin
      if (adv[LO_STAGES]) ref_sig  <= ~ref_sig;
      if (quad_step)      quad_sig <= ~quad_sig;
      if (ref_rise)       lead     <= quad_sig;
    end
  end

  AST_LO_Q_AT_REF: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> $stable(quad_sig)); // R5

  AST_LO_LEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ref_rise |=> $stable(lead)); // R5

endmodule

// File: rtl/qsd_sideband.sv
module qsd_sideband
  import qsd_pkg::*;
#(
  parameter int VALID_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_lower,
  input  logic lo_rise,
  input  logic quad_step,
  input  logic hi_q,
  input  logic lo_q,
  input  logic seed_q,
  output logic lo_q_fix,
  output logic valid
);

  localparam int CW = $clog2(VALID_EDGES + 1);

  logic          ctrl_q;
  logic          ctrl_n;
  logic [CW-1:0] edge_cnt;

  assign ctrl_n = qsd_fix_ctrl(sel_lower, hi_q, lo_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 1'b0;
      lo_q_fix <= seed_q;
      edge_cnt <= '0;
      valid    <= 1'b0;
    end else begin
      lo_q_fix <= lo_q_fix ^ quad_step ^ (lo_rise & (ctrl_n ^ ctrl_q));
      if (lo_rise) begin
        ctrl_q <= ctrl_n;
        if (edge_cnt != CW'(VALID_EDGES)) edge_cnt <= edge_cnt + 1'b1;
        if (edge_cnt == CW'(VALID_EDGES - 1)) valid <= 1'b1;
      end
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid); // R8

  AST_CTRL_ONLY_AT_REF: assert property (@(posedge clk) disable iff (rst)
    !lo_rise |=> $stable(ctrl_q)); // R9

endmodule

// File: rtl/quad_sideband_div.sv
module quad_sideband_div
  import qsd_pkg::*;
#(
  parameter int LO_STAGES   = 2,
  parameter int VALID_EDGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LO_STAGES+3:0] start_st,
  input  logic                 sel_lower,
  output logic                 hi_i,
  output logic                 hi_q,
  output logic                 lo_i,
  output logic                 lo_q,
  output logic                 lo_q_fix,
  output logic                 hi_lead,
  output logic                 lo_lead,
  output logic                 valid
);

  localparam int LO_I_BIT = LO_STAGES + 2;
  localparam int LO_Q_BIT = LO_STAGES + 3;

  qsd_pair_t hi_pair;
  qsd_pair_t lo_pair;
  logic      hi_rise;
  logic      lo_rise;
  logic      q_step;

  qsd_hi_pair u_hi (
    .clk      (clk),
    .rst      (rst),
    .seed_i   (start_st[0]),
    .seed_q   (start_st[1]),
    .ref_sig  (hi_pair.ref_sig),
    .quad_sig (hi_pair.quad_sig),
    .lead     (hi_pair.lead),
    .ref_rise (hi_rise)
  );

  qsd_lo_pair #(.LO_STAGES(LO_STAGES)) u_lo (
    .clk       (clk),
    .rst       (rst),
    .hi_rise   (hi_rise),
    .seed_pre  (start_st[2 +: LO_STAGES]),
    .seed_i    (start_st[LO_I_BIT]),
    .seed_q    (start_st[LO_Q_BIT]),
    .ref_sig   (lo_pair.ref_sig),
    .quad_sig  (lo_pair.quad_sig),
    .lead      (lo_pair.lead),
    .ref_rise  (lo_rise),
    .quad_step (q_step)
  );

  qsd_sideband #(.VALID_EDGES(VALID_EDGES)) u_sb (
    .clk       (clk),
    .rst       (rst),
    .sel_lower (sel_lower),
    .lo_rise   (lo_rise),
    .quad_step (q_step),
    .hi_q      (hi_pair.quad_sig),
    .lo_q      (lo_pair.quad_sig),
    .seed_q    (start_st[LO_Q_BIT]),
    .lo_q_fix  (lo_q_fix),
    .valid     (valid)
  );

  assign hi_i    = hi_pair.ref_sig;
  assign hi_q    = hi_pair.quad_sig;
  assign hi_lead = hi_pair.lead;
  assign lo_i    = lo_pair.ref_sig;
  assign lo_q    = lo_pair.quad_sig;
  assign lo_lead = lo_pair.lead;

  AST_FIX_SIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lo_rise)) |-> (lo_q_fix == ($past(sel_lower) ^ hi_lead))); // R7

  AST_FIX_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lo_rise) && !$past(q_step)) |-> $stable(lo_q_fix)); // R9

  AST_FIX_FOLLOWS_Q: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(q_step)) |-> (lo_q_fix != $past(lo_q_fix))); // R6

endmodule

// File: tb/test_quad_sideband_div.sv
module test_quad_sideband_div;

  localparam int L   = 2;
  localparam int SW  = L + 4;
  localparam int MOD = 1 << (L + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_lower = 1'b0;
  logic [SW-1:0] start_st = '0;
  logic hi_i, hi_q, lo_i, lo_q, lo_q_fix, hi_lead, lo_lead, valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int   mcnt;
  logic mq, mlq, efh, efl, ectrl;
  int   vcnt;
  bit   sel_pending;

  quad_sideband_div #(.LO_STAGES(L), .VALID_EDGES(2)) i_quad_sideband_div (
    .clk(clk), .rst(rst), .start_st(start_st), .sel_lower(sel_lower),
    .hi_i(hi_i), .hi_q(hi_q), .lo_i(lo_i), .lo_q(lo_q), .lo_q_fix(lo_q_fix),
    .hi_lead(hi_lead), .lo_lead(lo_lead), .valid(valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 hi_i", hi_i, logic'(mcnt & 1));
    chk("R2 hi_q", hi_q, mq);
    chk("R3 lo_i", lo_i, logic'((mcnt >> (L + 1)) & 1));
    chk("R3 lo_q", lo_q, mlq);
    chk("R4 hi_lead", hi_lead, efh);
    chk("R5 lo_lead", lo_lead, efl);
    chk(sel_pending ? "R9 lo_q_fix held" : "R6 lo_q_fix", lo_q_fix, mlq ^ ectrl);
    chk("R8 valid", valid, logic'(vcnt >= 2));
  endtask

  task automatic step();
    logic hr, xf, lr, sel_at;
    @(negedge clk);
    mq = ~mq;
    @(posedge clk);
    sel_at = sel_lower;
    hr = ((mcnt % 2) == 0);
    xf = ((mcnt % (1 << L)) == 0) && (((mcnt >> L) & 1) == 1);
    lr = ((mcnt % (1 << (L + 1))) == 0) && (((mcnt >> (L + 1)) & 1) == 0);
    if (hr) efh = mq;
    if (xf) mlq = ~mlq;
    if (lr) begin
      efl   = mlq;
      ectrl = sel_at ^ efh ^ mlq;
      if (vcnt < 2) vcnt++;
    end
    mcnt = (mcnt - 1 + MOD) % MOD;
    #2;
    compare_all();
    if (lr) begin
      sel_pending = 1'b0;
      if (vcnt >= 2) chk("R7 corrected sign", lo_q_fix, efh ^ sel_at);
    end
  endtask

  initial begin
    for (int s = 0; s < (1 << SW); s++) begin
      @(posedge clk); #2;
      rst       = 1'b1;
      start_st  = SW'(s);
      sel_lower = start_st[0] ^ start_st[SW-1];
      @(posedge clk);
      @(posedge clk); #2;
      // R1 reset state
      chk("R1 hi_i", hi_i, start_st[0]);
      chk("R1 hi_q", hi_q, start_st[1]);
      chk("R1 lo_i", lo_i, start_st[L+2]);
      chk("R1 lo_q", lo_q, start_st[L+3]);
      chk("R1 lo_q_fix", lo_q_fix, start_st[L+3]);
      chk("R1 hi_lead", hi_lead, 1'b0);
      chk("R1 lo_lead", lo_lead, 1'b0);
      chk("R1 valid", valid, 1'b0);
      mcnt = int'(start_st[0]);
      for (int j = 0; j < L; j++) mcnt += int'(start_st[2+j]) << (1 + j);
      mcnt += int'(start_st[L+2]) << (L + 1);
      mq = start_st[1]; mlq = start_st[L+3];
      efh = 1'b0; efl = 1'b0; ectrl = 1'b0; vcnt = 0; sel_pending = 1'b0;
      rst = 1'b0;
      for (int c = 0; c < 56; c++) begin
        step();
        if (c == 21 || c == 38) begin
          sel_lower   = ~sel_lower;
          sel_pending = 1'b1;
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule